// File: doc/BRIEF.md
# Raster line interrupt generator

This block watches the raster position reported by a display timing unit (current line, dot within the line, field flag) and raises single-clock interrupt pulses when that position reaches programmed targets. Two independent vertical compares fire at the start of a chosen line. A third, horizontal interrupt fires at a chosen dot inside a chosen line. It can fire once per frame, or it can repeat every N lines or on every line with a target that moves forward after each firing.

Programmed line numbers count field lines. The block expands a value L to raster line 2L in the even field and to 2L+1 in the odd field. When interlace is off, the field flag is ignored and the even expansion is used. Two register write strobes share one 32-bit write data bus. Combining the pulses in an interrupt controller and acknowledging them in software are handled outside this block.

Top module: `raster_line_irq`

## Requirements
- R1: A vertical write takes compare line A from data bits 25:16 and compare line B from bits 9:0. All other data bits have no effect.
- R2: A vertical compare with line L pulses its output when the raster is at dot 0 of line 2L+f, where f is 1 in an odd field with interlace on and 0 otherwise. The pulse appears one clock after the clock on which that position is presented.
- R3: A compare whose expanded line is not below the total line count never pulses.
- R4: Every interrupt output is high for exactly one clock per match.
- R5: A horizontal write takes line L from data bits 9:0, mode from bits 13:12 and dot position P from bits 25:16. Bits 15:14, 11:10 and 31:26 have no effect.
- R6: In mode 0, and in mode 3 which behaves the same, the horizontal interrupt fires at line L (expanded as in R2) on every pass of the raster.
- R7: In mode 1 the step N is L. After each firing the target advances by N. While the target exceeds half the total lines, half the total is subtracted from it.
- R8: In mode 2 the target behaves as in mode 1 with N = 1, whatever L holds.
- R9: The horizontal interrupt fires at dot 2P. When 2P is not below the line length, it fires at dot (line length - 1) instead.
- R10: On a write selecting mode 1 or 2, the first target is (current raster line / 2) + N, reduced as in R7.
- R11: After reset all outputs are low and all programmed values are zero: the vertical compares target line 0 and the horizontal interrupt is in mode 0 at line 0, dot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_i | input | LINE_W | Current raster line |
| dot_i | input | LINE_W+1 | Current dot within the line |
| odd_field_i | input | 1 | High during the odd field |
| interlace_i | input | 1 | Interlaced scan enabled |
| total_lines_i | input | LINE_W+1 | Lines per frame |
| line_len_i | input | LINE_W+1 | Dots per line |
| vint_we_i | input | 1 | Write strobe for the vertical compare register |
| hint_we_i | input | 1 | Write strobe for the horizontal interrupt register |
| wdata_i | input | 32 | Write data |
| irq_v1_o | output | 1 | Vertical compare A pulse |
| irq_v2_o | output | 1 | Vertical compare B pulse |
| irq_h_o | output | 1 | Horizontal interrupt pulse |

## Verification
The assertions assume a well-formed raster. The dot advances by one per clock and wraps at the line length. The line advances only on a dot wrap. The field flag toggles only when the line wraps. The total line count is at least two, and it and the line length change only while the raster is parked. The bench derives all raster inputs from one position counter, so these relations hold by construction. Line count and line length change only between runs. Register writes happen only while the raster is parked, at a position chosen so that no target matches there.

// File: rtl/raster_line_irq.sv
module raster_line_irq #(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_i,
  input  logic [LINE_W:0]   dot_i,
  input  logic              odd_field_i,
  input  logic              interlace_i,
  input  logic [LINE_W:0]   total_lines_i,
  input  logic [LINE_W:0]   line_len_i,
  input  logic              vint_we_i,
  input  logic              hint_we_i,
  input  logic [31:0]       wdata_i,
  output logic              irq_v1_o,
  output logic              irq_v2_o,
  output logic              irq_h_o
);

  localparam int TW = LINE_W + 1;

  logic [LINE_W-1:0] v1_q, v2_q, h_pos_q, h_n_q;
  logic [TW-1:0]     h_tgt_q;
  logic              h_rep_q, h_busy_q;
  logic [2:0]        hit_q;

  logic          fsel;
  logic [TW-1:0] half, line_x, exp1, exp2, off_raw, off;
  logic [TW:0]   exp_h;
  logic          hit_v1, hit_v2, hit_h;
  logic [1:0]    wmode;
  logic [LINE_W-1:0] n_new;
  logic          unused_bits;

  assign fsel    = interlace_i & odd_field_i;
  assign half    = total_lines_i >> 1;
  assign line_x  = {1'b0, line_i};
  assign exp1    = {v1_q, fsel};
  assign exp2    = {v2_q, fsel};
  assign exp_h   = {h_tgt_q, fsel};
  assign off_raw = {h_pos_q, 1'b0};
  assign off     = (off_raw >= line_len_i) ? line_len_i - TW'(1) : off_raw;

  assign hit_v1 = (dot_i == '0) && (line_x == exp1) && (exp1 < total_lines_i);
  assign hit_v2 = (dot_i == '0) && (line_x == exp2) && (exp2 < total_lines_i);
  assign hit_h  = !h_busy_q && (dot_i == off) && ({1'b0, line_x} == exp_h)
                  && (exp_h < {1'b0, total_lines_i});

  assign wmode = wdata_i[13:12];
  assign n_new = (wmode == 2'd2) ? LINE_W'(1) : wdata_i[LINE_W-1:0];
  assign unused_bits = ^{wdata_i[31:16+LINE_W], wdata_i[15:14], wdata_i[11:LINE_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q     <= '0;
      v2_q     <= '0;
      h_pos_q  <= '0;
      h_n_q    <= '0;
      h_tgt_q  <= '0;
      h_rep_q  <= 1'b0;
      h_busy_q <= 1'b0;
      hit_q    <= '0;
      irq_v1_o <= 1'b0;
      irq_v2_o <= 1'b0;
      irq_h_o  <= 1'b0;
    end else begin
      hit_q    <= {hit_h, hit_v2, hit_v1};
      irq_v1_o <= hit_v1 & ~hit_q[0];
      irq_v2_o <= hit_v2 & ~hit_q[1];
      irq_h_o  <= hit_h & ~hit_q[2];

      if (vint_we_i) begin
        v1_q <= wdata_i[16 +: LINE_W];
        v2_q <= wdata_i[0 +: LINE_W];
      end

      if (hint_we_i) begin
        h_pos_q <= wdata_i[16 +: LINE_W];
        if (wmode == 2'd1 || wmode == 2'd2) begin
          h_rep_q  <= 1'b1;
          h_n_q    <= n_new;
          h_tgt_q  <= TW'(line_i >> 1) + TW'(n_new);
          h_busy_q <= 1'b1;
        end else begin
          h_rep_q  <= 1'b0;
          h_tgt_q  <= {1'b0, wdata_i[LINE_W-1:0]};
          h_busy_q <= 1'b0;
        end
      end else if (h_busy_q) begin
        if (h_tgt_q > half && half != '0) h_tgt_q <= h_tgt_q - half;
        else                              h_busy_q <= 1'b0;
      end else if (h_rep_q && hit_h && !hit_q[2]) begin
        h_tgt_q  <= h_tgt_q + TW'(h_n_q);
        h_busy_q <= 1'b1;
      end
    end
  end

  // R2: a vertical pulse follows a clock at dot 0 of the expanded line
  p_v1_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_v1_o |-> ($past(line_x) == $past(exp1)) && ($past(dot_i) == '0));
  p_v2_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_v2_o |-> ($past(line_x) == $past(exp2)) && ($past(dot_i) == '0));

  // R3: no pulse for an expanded line outside the frame
  p_v1_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_v1_o |-> $past(exp1) < $past(total_lines_i));

  // R9: the horizontal pulse lands on a dot inside the line
  p_h_dot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_h_o |-> $past(dot_i) < $past(line_len_i));

  // R7: no firing while the target is being reduced
  p_h_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    h_busy_q |=> !irq_h_o);

  // R7: a settled repeating target never exceeds half the frame
  p_h_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rep_q && !h_busy_q && total_lines_i > TW'(1)) |-> h_tgt_q <= half);

endmodule

// File: tb/sim_raster_line_irq.sv
`timescale 1ns/1ps
module sim_raster_line_irq;
  localparam int LW = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic [LW-1:0] line_i;
  logic [LW:0]   dot_i, total_i, len_i;
  logic          odd_i, il_i, vwe, hwe;
  logic [31:0]   wd;
  logic          irq_v1, irq_v2, irq_h;

  raster_line_irq #(.LINE_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .dot_i(dot_i),
    .odd_field_i(odd_i), .interlace_i(il_i), .total_lines_i(total_i),
    .line_len_i(len_i), .vint_we_i(vwe), .hint_we_i(hwe), .wdata_i(wd),
    .irq_v1_o(irq_v1), .irq_v2_o(irq_v2), .irq_h_o(irq_h));

  int rc = 0, prev_rc = 0, rc_ld = 0, tl = 22, ll = 12;
  bit run = 0, load = 0, mon_en = 0, il = 0;
  int n_chk = 0, n_fail = 0;
  int qv1[$], qv2[$], qh[$];
  string cur_tag = "";
  bit last_v1 = 0, last_v2 = 0, last_h = 0;

  // expected register state, kept from the requirements
  int m_v1 = 0, m_v2 = 0, m_pos = 0, m_n = 0, m_tgt = 0;
  bit m_rep = 0;

  always @(posedge clk) begin
    prev_rc <= rc;
    if (load) rc <= rc_ld;
    else if (run) rc <= rc + 1;
  end

  always_comb begin
    line_i  = LW'((rc / ll) % tl);
    dot_i   = (LW+1)'(rc % ll);
    odd_i   = ((rc / (tl * ll)) % 2) == 1;
    il_i    = il;
    total_i = (LW+1)'(tl);
    len_i   = (LW+1)'(ll);
  end

  task automatic check(string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // monitor: pops the expected position of each pulse and compares
  always @(negedge clk) begin
    if (mon_en) begin
      if (irq_v1) begin
        check({cur_tag, " R4 v1 width"}, int'(last_v1), 0);
        if (qv1.size() == 0) check({cur_tag, " v1 unexpected pulse"}, prev_rc, -1);
        else check({cur_tag, " v1 position"}, prev_rc, qv1.pop_front());
      end
      if (irq_v2) begin
        check({cur_tag, " R4 v2 width"}, int'(last_v2), 0);
        if (qv2.size() == 0) check({cur_tag, " v2 unexpected pulse"}, prev_rc, -1);
        else check({cur_tag, " v2 position"}, prev_rc, qv2.pop_front());
      end
      if (irq_h) begin
        check({cur_tag, " R4 h width"}, int'(last_h), 0);
        if (qh.size() == 0) check({cur_tag, " h unexpected pulse"}, prev_rc, -1);
        else check({cur_tag, " h position"}, prev_rc, qh.pop_front());
      end
    end
    last_v1 = irq_v1;
    last_v2 = irq_v2;
    last_h  = irq_h;
  end

  task automatic scn(string tag, int tl_, int ll_, bit il_, bit wv, bit [31:0] vw,
                     bit wh, bit [31:0] hw, int p0, int frames);
    int half, nrun, mode;
    @(negedge clk);
    mon_en = 0; run = 0;
    tl = tl_; ll = ll_; il = il_;
    rc_ld = p0; load = 1;
    @(negedge clk);
    load = 0;
    half = tl / 2;
    if (wv) begin
      vwe = 1; wd = vw; @(negedge clk); vwe = 0;
      m_v1 = int'((vw >> 16) & 32'h3FF);
      m_v2 = int'(vw & 32'h3FF);
    end
    if (wh) begin
      hwe = 1; wd = hw; @(negedge clk); hwe = 0;
      mode  = int'((hw >> 12) & 32'h3);
      m_pos = int'((hw >> 16) & 32'h3FF);
      if (mode == 1 || mode == 2) begin
        m_rep = 1;
        m_n   = (mode == 2) ? 1 : int'(hw & 32'h3FF);
        m_tgt = ((p0 / ll) % tl) / 2 + m_n;
        while (half > 0 && m_tgt > half) m_tgt -= half;
      end else begin
        m_rep = 0;
        m_tgt = int'(hw & 32'h3FF);
      end
    end
    repeat (40) @(negedge clk);
    nrun = frames * tl * ll;
    for (int p = p0; p <= p0 + nrun; p++) begin
      int ln, dt, fr, e1, e2, eh, off;
      ln  = (p / ll) % tl;
      dt  = p % ll;
      fr  = il ? (p / (tl * ll)) % 2 : 0;
      e1  = 2 * m_v1 + fr;
      e2  = 2 * m_v2 + fr;
      eh  = 2 * m_tgt + fr;
      off = 2 * m_pos;
      if (off >= ll) off = ll - 1;
      if (p != p0) begin
        if (dt == 0 && e1 < tl && ln == e1) qv1.push_back(p);
        if (dt == 0 && e2 < tl && ln == e2) qv2.push_back(p);
        if (dt == off && eh < tl && ln == eh) begin
          qh.push_back(p);
          if (m_rep) begin
            m_tgt += m_n;
            while (half > 0 && m_tgt > half) m_tgt -= half;
          end
        end
      end
    end
    cur_tag = tag;
    mon_en = 1; run = 1;
    repeat (nrun) @(negedge clk);
    run = 0;
    repeat (4) @(negedge clk);
    mon_en = 0;
    check({tag, " missing v1 pulses"}, qv1.size(), 0);
    check({tag, " missing v2 pulses"}, qv2.size(), 0);
    check({tag, " missing h pulses"}, qh.size(), 0);
    qv1.delete(); qv2.delete(); qh.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; vwe = 0; hwe = 0; wd = '0;
    rc_ld = 1; load = 1;
    repeat (3) @(negedge clk);
    load = 0;
    check("R11 reset irq_v1", int'(irq_v1), 0);
    check("R11 reset irq_v2", int'(irq_v2), 0);
    check("R11 reset irq_h", int'(irq_h), 0);
    rst_n = 1;
    // reset values: all targets at line 0, dot 0
    scn("R11 R6 defaults", 22, 12, 0, 0, 32'h0, 0, 32'h0, 1, 1);
    // junk bits outside the fields; line A = 5, line B = 3
    scn("R1 R2 progressive", 22, 12, 0, 1, 32'hFC05_C003, 1, 32'h0000_0014, 1, 2);
    // interlaced expansion; mode 3 behaves like mode 0, dot 6
    scn("R2 R6 interlaced", 22, 12, 1, 1, 32'h0004_000A, 1, 32'h0003_3002, 1, 2);
    // lines 22 and 30 out of frame; dot 18 clamped to 11
    scn("R3 R9 range clamp", 22, 12, 1, 1, 32'h000B_000F, 1, 32'h0009_0007, 1, 2);
    // mode 1, N = 3, written while parked on line 5; junk bits 15:14, 31:26
    scn("R5 R7 R10 step", 22, 12, 0, 1, 32'h000B_000B, 1, 32'hFC00_D003, 61, 3);
    // mode 2 ignores the line field
    scn("R8 every line", 23, 12, 1, 0, 32'h0, 1, 32'h0001_2009, 1, 2);
    // N = 25 larger than half the frame: multi-step reduction
    scn("R7 R10 wrap", 22, 12, 0, 0, 32'h0, 1, 32'h0002_1019, 1, 2);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule